// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Prioritizer

This block collects interrupt events from two serial channels, called A and B, and turns them into one interrupt request towards a processor. Each channel has three sources: receive, transmit and external/status change. The receive source also carries a special-condition flavour. The channel datapaths are outside the block and reach it only as event strobes, a transmit-buffer-empty level and a small status input vector. The block keeps a pending bit and an in-service bit for each of the six sources. From these it resolves a fixed priority with in-service nesting and drives a request line. It also drives a vector that encodes the winning source's type and channel, and a six-bit pending summary.

Software uses a small write port with four selectable targets. Target 0 takes commands, target 1 takes per-channel interrupt modes, target 2 takes master control and target 3 takes the vector base. An interrupt acknowledge strobe moves the winning source into service. A reset-highest-in-service command ends service of the most urgent in-service source. A daisy-chain enable input and output let several such blocks share one request line.

Top module: `ser_irq_prio`

## Requirements
- R1: After reset, irq_o is 0, ip_sum_o is 0, vec_o is 0 (base reset to 0) and master enable is clear; ieo_o follows iei_i.
- R2: Fixed priority, from highest to lowest, is source index 0..5: A receive, A transmit, A ext/status, B receive, B transmit, B ext/status. The vector describes the highest-priority source that is pending and not blocked.
- R3: vec_o is {base[7:4], chan, type[1:0], base[0]}. chan is 1 for channel A and 0 for channel B. type is 00 transmit empty, 01 ext/status, 10 receive character, 11 receive special condition. With no eligible source, vec_o equals the base.
- R4: ip_sum_o bit 5 is A receive, bit 4 A transmit, bit 3 A ext/status, bit 2 B receive, bit 1 B transmit and bit 0 B ext/status pending.
- R5: intack_i while irq_o is high sets the in-service bit of the winning source. A pending source whose priority is equal to or lower than any in-service source cannot raise irq_o. A higher-priority source still can (nesting).
- R6: Command code 4 (reset highest in-service) clears only the highest-priority set in-service bit.
- R7: A transmit pending is set when tx_empty_i rises with the transmit enable set. It is cleared by command code 3 or when tx_empty_i falls. No new one is raised while the buffer stays empty.
- R8: With ext/status enabled, a change on a channel's status input sets its pending bit and freezes stat_*_o at the value that caused it. Later changes are ignored until command code 1 clears the pending bit and re-arms detection from the current input.
- R9: Receive mode field (config bits [3:2]): 00 off, 01 first character only, 10/11 every character. In first-character mode only the first character after reset or after command code 2 raises receive pending. A special condition raises it in any non-off mode. rx_read_i clears it.
- R10: irq_o is never high while master enable (master bit 0) is clear. With the no-vector bit (master bit 1) set, vec_o equals the base.
- R11: With iei_i low, irq_o is low. ieo_o is high only when iei_i is high, the disable-lower-chain bit (master bit 2) is clear and no source is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Target: 0 command, 1 channel config, 2 master control, 3 vector base |
| reg_chan_i | input | 1 | Channel for command/config: 0 A, 1 B |
| reg_wdata_i | input | 8 | Write data; command code in bits [2:0]; config bit0 ext enable, bit1 tx enable, bits[3:2] receive mode |
| rx_char_i | input | 2 | Received-character strobe per channel (bit 0 = A) |
| rx_spec_i | input | 2 | Special receive condition strobe per channel |
| rx_read_i | input | 2 | Receive data read strobe per channel |
| tx_empty_i | input | 2 | Transmit buffer empty level per channel |
| stat_a_i | input | 2 | Channel A external status inputs |
| stat_b_i | input | 2 | Channel B external status inputs |
| intack_i | input | 1 | Interrupt acknowledge strobe |
| iei_i | input | 1 | Daisy-chain enable in |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 8 | Interrupt vector |
| ip_sum_o | output | 6 | Pending summary |
| ieo_o | output | 1 | Daisy-chain enable out |
| stat_a_o | output | 2 | Channel A status as seen by software (frozen while latched) |
| stat_b_o | output | 2 | Channel B status as seen by software (frozen while latched) |

## Verification
Every strobe, register write and acknowledge is taken at one rising edge. The pending and in-service state updates at that same edge, and irq_o, vec_o, ip_sum_o, ieo_o and the status read-back follow it combinationally. Each result is therefore due one cycle after the stimulus. ieo_o and irq_o react to iei_i with no cycle of delay. The bench drives every input at a falling edge and holds it for one full cycle. It then compares at the next falling edge, which lies half a period after the edge that captured the stimulus and half a period before the next one. An exhaustive sweep over all 64 pending patterns checks priority, vector and summary arithmetically.

// File: rtl/ser_irq_pkg.sv
package ser_irq_pkg;
  localparam int NCH        = 2;
  localparam int SRC_PER_CH = 3;
  localparam int NSRC       = NCH * SRC_PER_CH;

  // source slot inside a channel group; order is priority
  localparam int K_RX  = 0;
  localparam int K_TX  = 1;
  localparam int K_EXT = 2;

  typedef enum logic [1:0] {
    VT_TX   = 2'b00,
    VT_EXT  = 2'b01,
    VT_RX   = 2'b10,
    VT_SPEC = 2'b11
  } vtype_e;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_RST_EXT = 3'd1,
    CMD_ARM_RX  = 3'd2,
    CMD_RST_TX  = 3'd3,
    CMD_RST_IUS = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    RXM_OFF   = 2'd0,
    RXM_FIRST = 2'd1,
    RXM_ALL   = 2'd2,
    RXM_ALLX  = 2'd3
  } rxm_e;

  typedef struct packed {
    rxm_e rxm;
    logic tx_ie;
    logic ext_ie;
  } ch_cfg_t;

  typedef struct packed {
    logic ext;
    logic tx;
    logic rx;
  } ch_pend_t;
endpackage

// File: rtl/ser_irq_regs.sv
module ser_irq_regs
  import ser_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [1:0]           sel_i,
  input  logic                 chan_i,
  input  logic [DW-1:0]        wdata_i,
  output ch_cfg_t [NCH-1:0]    cfg_o,
  output logic                 mie_o,
  output logic                 nov_o,
  output logic                 dlc_o,
  output logic [DW-1:0]        base_o,
  output logic [NCH-1:0]       rst_ext_o,
  output logic [NCH-1:0]       arm_rx_o,
  output logic [NCH-1:0]       rst_tx_o,
  output logic                 rst_ius_o
);
  localparam logic [1:0] SEL_CMD = 2'd0;
  localparam logic [1:0] SEL_CFG = 2'd1;
  localparam logic [1:0] SEL_MST = 2'd2;
  localparam logic [1:0] SEL_VEC = 2'd3;

  ch_cfg_t [NCH-1:0] cfg_q;
  logic              mie_q, nov_q, dlc_q;
  logic [DW-1:0]     base_q;
  logic              is_cmd;
  cmd_e              cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      mie_q  <= 1'b0;
      nov_q  <= 1'b0;
      dlc_q  <= 1'b0;
      base_q <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        SEL_CFG: cfg_q[chan_i] <= ch_cfg_t'(wdata_i[3:0]);
        SEL_MST: begin
          mie_q <= wdata_i[0];
          nov_q <= wdata_i[1];
          dlc_q <= wdata_i[2];
        end
        SEL_VEC: base_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign is_cmd    = we_i && (sel_i == SEL_CMD);
  assign cmd       = cmd_e'(wdata_i[2:0]);
  assign rst_ius_o = is_cmd && (cmd == CMD_RST_IUS);

  for (genvar c = 0; c < NCH; c++) begin : g_cmd
    logic hit;
    assign hit          = is_cmd && (chan_i == 1'(c));
    assign rst_ext_o[c] = hit && (cmd == CMD_RST_EXT);
    assign arm_rx_o[c]  = hit && (cmd == CMD_ARM_RX);
    assign rst_tx_o[c]  = hit && (cmd == CMD_RST_TX);
  end

  assign cfg_o  = cfg_q;
  assign mie_o  = mie_q;
  assign nov_o  = nov_q;
  assign dlc_o  = dlc_q;
  assign base_o = base_q;
endmodule

// File: rtl/ser_irq_src.sv
module ser_irq_src
  import ser_irq_pkg::*;
#(
  parameter int SW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ch_cfg_t       cfg_i,
  input  logic          rx_char_i,
  input  logic          rx_spec_i,
  input  logic          rx_read_i,
  input  logic          tx_empty_i,
  input  logic [SW-1:0] stat_i,
  input  logic          rst_ext_i,
  input  logic          arm_rx_i,
  input  logic          rst_tx_i,
  output ch_pend_t      pend_o,
  output logic          spec_o,
  output logic [SW-1:0] stat_o
);
  logic          armed_q, rx_q, spec_q, tx_q, empty_q, ext_q, latch_q;
  logic [SW-1:0] snap_q;
  logic          rx_all, rx_hit, spec_hit, tx_rise, changed;

  assign rx_all   = (cfg_i.rxm == RXM_ALL) || (cfg_i.rxm == RXM_ALLX);
  assign rx_hit   = rx_char_i && (rx_all || (cfg_i.rxm == RXM_FIRST && armed_q));
  assign spec_hit = rx_spec_i && (cfg_i.rxm != RXM_OFF);
  assign tx_rise  = tx_empty_i && !empty_q;
  assign changed  = stat_i != snap_q;

  // receive: first-character arming, pending, special flavour
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      rx_q    <= 1'b0;
      spec_q  <= 1'b0;
    end else begin
      if (rx_char_i && cfg_i.rxm == RXM_FIRST && armed_q) armed_q <= 1'b0;
      else if (arm_rx_i)                                   armed_q <= 1'b1;
      if (rx_read_i) begin
        rx_q   <= 1'b0;
        spec_q <= 1'b0;
      end else begin
        if (rx_hit || spec_hit) rx_q   <= 1'b1;
        if (spec_hit)           spec_q <= 1'b1;
      end
    end
  end

  // transmit: edge of buffer-empty raises pending once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= 1'b0;
      tx_q    <= 1'b0;
    end else begin
      empty_q <= tx_empty_i;
      if (rst_tx_i || !tx_empty_i)   tx_q <= 1'b0;
      else if (tx_rise && cfg_i.tx_ie) tx_q <= 1'b1;
    end
  end

  // ext/status: snapshot follows input until a change latches it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q   <= 1'b0;
      latch_q <= 1'b0;
      snap_q  <= '0;
    end else if (rst_ext_i) begin
      ext_q   <= 1'b0;
      latch_q <= 1'b0;
      snap_q  <= stat_i;
    end else if (!latch_q) begin
      snap_q <= stat_i;
      if (changed && cfg_i.ext_ie) begin
        ext_q   <= 1'b1;
        latch_q <= 1'b1;
      end
    end
  end

  assign pend_o.rx  = rx_q;
  assign pend_o.tx  = tx_q;
  assign pend_o.ext = ext_q;
  assign spec_o     = spec_q;
  assign stat_o     = latch_q ? snap_q : stat_i;
endmodule

// File: rtl/ser_irq_arb.sv
module ser_irq_arb
  import ser_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  pend_i,
  input  logic [NCH-1:0]   spec_i,
  input  logic             mie_i,
  input  logic             nov_i,
  input  logic             dlc_i,
  input  logic [DW-1:0]    base_i,
  input  logic             iei_i,
  input  logic             intack_i,
  input  logic             rst_ius_i,
  output logic             irq_o,
  output logic [DW-1:0]    vec_o,
  output logic [NSRC-1:0]  ius_o,
  output logic             ieo_o,
  output logic [NSRC-1:0]  sum_o
);
  logic [NSRC-1:0] ius_q, ius_clr, elig, win_oh;
  logic            found, win_a;
  vtype_e          win_t;

  // eligible: pending and no in-service bit at equal or higher priority
  always_comb begin
    logic blk;
    blk  = 1'b0;
    elig = '0;
    for (int i = 0; i < NSRC; i++) begin
      blk     = blk | ius_q[i];
      elig[i] = pend_i[i] & ~blk;
    end
  end

  always_comb begin
    found  = 1'b0;
    win_oh = '0;
    win_a  = 1'b0;
    win_t  = VT_TX;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && !found) begin
        found     = 1'b1;
        win_oh[i] = 1'b1;
        win_a     = (i / SRC_PER_CH) == 0;
        case (i % SRC_PER_CH)
          K_RX:    win_t = spec_i[i / SRC_PER_CH] ? VT_SPEC : VT_RX;
          K_TX:    win_t = VT_TX;
          default: win_t = VT_EXT;
        endcase
      end
    end
  end

  assign irq_o   = mie_i && iei_i && found;
  assign ius_clr = rst_ius_i ? (ius_q & (ius_q - NSRC'(1))) : ius_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ius_q <= '0;
    else if (intack_i && irq_o) ius_q <= ius_clr | win_oh;
    else                       ius_q <= ius_clr;
  end

  assign vec_o = (nov_i || !found) ? base_i
               : {base_i[DW-1:4], win_a, win_t, base_i[0]};
  assign ieo_o = iei_i && !dlc_i && (ius_q == '0);
  assign ius_o = ius_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_sum
    assign sum_o[NSRC-1-i] = pend_i[i];
  end
endmodule

// File: rtl/ser_irq_prio.sv
module ser_irq_prio
  import ser_irq_pkg::*;
#(
  parameter int DW = 8,
  parameter int SW = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [1:0]      reg_sel_i,
  input  logic            reg_chan_i,
  input  logic [DW-1:0]   reg_wdata_i,
  input  logic [1:0]      rx_char_i,
  input  logic [1:0]      rx_spec_i,
  input  logic [1:0]      rx_read_i,
  input  logic [1:0]      tx_empty_i,
  input  logic [SW-1:0]   stat_a_i,
  input  logic [SW-1:0]   stat_b_i,
  input  logic            intack_i,
  input  logic            iei_i,
  output logic            irq_o,
  output logic [DW-1:0]   vec_o,
  output logic [5:0]      ip_sum_o,
  output logic            ieo_o,
  output logic [SW-1:0]   stat_a_o,
  output logic [SW-1:0]   stat_b_o
);
  ch_cfg_t [NCH-1:0] cfg;
  logic              mie_q, nov_q, dlc_q, rst_ius;
  logic [DW-1:0]     base_q;
  logic [NCH-1:0]    rst_ext, arm_rx, rst_tx, spec;
  logic [NSRC-1:0]   pend_vec, ius_q;
  logic [SW-1:0]     stat_in  [NCH];
  logic [SW-1:0]     stat_out [NCH];

  assign stat_in[0] = stat_a_i;
  assign stat_in[1] = stat_b_i;
  assign stat_a_o   = stat_out[0];
  assign stat_b_o   = stat_out[1];

  ser_irq_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .chan_i(reg_chan_i), .wdata_i(reg_wdata_i),
    .cfg_o(cfg), .mie_o(mie_q), .nov_o(nov_q), .dlc_o(dlc_q), .base_o(base_q),
    .rst_ext_o(rst_ext), .arm_rx_o(arm_rx), .rst_tx_o(rst_tx), .rst_ius_o(rst_ius)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ch_pend_t p;
    ser_irq_src #(.SW(SW)) u_src (
      .clk_i, .rst_ni, .cfg_i(cfg[c]),
      .rx_char_i(rx_char_i[c]), .rx_spec_i(rx_spec_i[c]), .rx_read_i(rx_read_i[c]),
      .tx_empty_i(tx_empty_i[c]), .stat_i(stat_in[c]),
      .rst_ext_i(rst_ext[c]), .arm_rx_i(arm_rx[c]), .rst_tx_i(rst_tx[c]),
      .pend_o(p), .spec_o(spec[c]), .stat_o(stat_out[c])
    );
    assign pend_vec[c*SRC_PER_CH + K_RX]  = p.rx;
    assign pend_vec[c*SRC_PER_CH + K_TX]  = p.tx;
    assign pend_vec[c*SRC_PER_CH + K_EXT] = p.ext;
  end

  ser_irq_arb #(.DW(DW)) u_arb (
    .clk_i, .rst_ni, .pend_i(pend_vec), .spec_i(spec),
    .mie_i(mie_q), .nov_i(nov_q), .dlc_i(dlc_q), .base_i(base_q),
    .iei_i, .intack_i, .rst_ius_i(rst_ius),
    .irq_o, .vec_o, .ius_o(ius_q), .ieo_o, .sum_o(ip_sum_o)
  );
endmodule

// File: rtl/ser_irq_prio_chk.sv
module ser_irq_prio_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          irq_o,
  input logic          ieo_o,
  input logic          iei_i,
  input logic          intack_i,
  input logic [DW-1:0] vec_o,
  input logic [5:0]    ip_sum_o,
  input logic          mie_q,
  input logic          nov_q,
  input logic [DW-1:0] base_q,
  input logic [5:0]    ius_q,
  input logic [5:0]    pend_vec
);
  AST_IRQ_NEEDS_MIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mie_q |-> !irq_o); // R10
  AST_NOV_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nov_q |-> vec_o == base_q); // R10
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_vec != '0); // R2
  AST_SUM_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ip_sum_o) == $countones(pend_vec)); // R4
  AST_ONE_NEW_IUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ius_q & ~$past(ius_q)) <= 1); // R5
  AST_ACK_SETS_IUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intack_i && irq_o) |=> ius_q != '0); // R5
  AST_CHAIN_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iei_i |-> (!irq_o && !ieo_o)); // R11
endmodule

bind ser_irq_prio ser_irq_prio_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_ser_irq_prio.sv
module sim_ser_irq_prio;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 0, reg_chan = 0, intack = 0, iei = 1;
  logic [1:0] reg_sel = 0, rx_char = 0, rx_spec = 0, rx_read = 0, tx_empty = 0;
  logic [7:0] reg_wdata = 0;
  logic [1:0] stat_a = 0, stat_b = 0;
  logic       irq, ieo;
  logic [7:0] vec;
  logic [5:0] sum;
  logic [1:0] stat_a_q, stat_b_q;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 0;

  localparam logic [7:0] BASE = 8'hA1;

  always #4 clk = ~clk;

  ser_irq_prio u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_chan_i(reg_chan), .reg_wdata_i(reg_wdata), .rx_char_i(rx_char),
    .rx_spec_i(rx_spec), .rx_read_i(rx_read), .tx_empty_i(tx_empty),
    .stat_a_i(stat_a), .stat_b_i(stat_b), .intack_i(intack), .iei_i(iei),
    .irq_o(irq), .vec_o(vec), .ip_sum_o(sum), .ieo_o(ieo),
    .stat_a_o(stat_a_q), .stat_b_o(stat_b_q)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // expected vector for source index idx (-1: none)
  function automatic logic [7:0] ev(input int idx, input bit sp);
    logic [1:0] t;
    if (idx < 0) return BASE;
    case (idx % 3)
      0:       t = sp ? 2'b11 : 2'b10;
      1:       t = 2'b00;
      default: t = 2'b01;
    endcase
    return {BASE[7:4], (idx < 3) ? 1'b1 : 1'b0, t, BASE[0]};
  endfunction

  function automatic logic [5:0] esum(input logic [5:0] m);
    logic [5:0] s;
    for (int i = 0; i < 6; i++) s[5-i] = m[i];
    return s;
  endfunction

  task automatic wr(input logic [1:0] sel, input logic ch, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_chan = ch; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); intack = 1; @(negedge clk); intack = 0;
  endtask

  task automatic rdx(input logic [1:0] m);
    @(negedge clk); rx_read = m; @(negedge clk); rx_read = 0;
  endtask

  task automatic rxc(input logic [1:0] m);
    @(negedge clk); rx_char = m; @(negedge clk); rx_char = 0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 sum", sum, 0);
    chk("R1 vec", vec, 0);
    chk("R1 ieo", ieo, 1);

    wr(1, 0, 8'h0B); wr(1, 1, 8'h0B); wr(3, 0, BASE);
    // R10 master enable clear blocks request
    rxc(2'b01);
    chk("R10 irq with mie clear", irq, 0);
    chk("R4 sum A rx", sum, 6'b100000);
    wr(2, 0, 8'h01);
    chk("R10 irq after mie", irq, 1);
    chk("R3 vec A rx", vec, ev(0, 0));
    wr(2, 0, 8'h03);
    chk("R10 no-vector", vec, BASE);
    wr(2, 0, 8'h01);
    rdx(2'b01);
    chk("R9 read clears", sum, 0);

    // R2 R3 R4 exhaustive over pending patterns
    for (int m = 0; m < 64; m++) begin
      int lo;
      lo = -1;
      for (int i = 5; i >= 0; i--) if (m[i]) lo = i;
      @(negedge clk);
      rx_char  = {m[3], m[0]};
      tx_empty = {m[4], m[1]};
      if (m[2]) stat_a = stat_a ^ 2'b01;
      if (m[5]) stat_b = stat_b ^ 2'b01;
      @(negedge clk);
      rx_char = 0;
      chk("R4 sweep sum", sum, esum(6'(m)));
      chk("R2 sweep irq", irq, (m != 0));
      chk("R3 sweep vec", vec, ev(lo, 0));
      @(negedge clk); rx_read = 2'b11; tx_empty = 0;
      @(negedge clk); rx_read = 0;
      wr(0, 0, 8'h01); wr(0, 1, 8'h01);
      chk("R2 sweep clear", sum, 0);
    end

    // R9 first-character mode
    wr(1, 0, 8'h07);
    rxc(2'b01);
    chk("R9 first char", sum, 6'b100000);
    rdx(2'b01);
    rxc(2'b01);
    chk("R9 second char ignored", sum, 0);
    chk("R9 second char irq", irq, 0);
    @(negedge clk); rx_spec = 2'b01; @(negedge clk); rx_spec = 0;
    chk("R9 special raises", sum, 6'b100000);
    chk("R3 special vec", vec, ev(0, 1));
    rdx(2'b01);
    wr(0, 0, 8'h02);
    rxc(2'b01);
    chk("R9 rearmed char", sum, 6'b100000);
    rdx(2'b01);
    wr(1, 0, 8'h0B);

    // R7 transmit pending
    @(negedge clk); tx_empty = 2'b01; @(negedge clk);
    chk("R7 tx set", sum, 6'b010000);
    wr(0, 0, 8'h03);
    chk("R7 tx reset", sum, 0);
    cyc(3);
    chk("R7 stays empty no new", sum, 0);
    @(negedge clk); tx_empty = 0; @(negedge clk); tx_empty = 2'b01; @(negedge clk);
    chk("R7 tx again", sum, 6'b010000);
    @(negedge clk); tx_empty = 0; @(negedge clk);
    chk("R7 fall clears", sum, 0);

    // R8 ext/status latching
    @(negedge clk); stat_a = stat_a ^ 2'b10; @(negedge clk);
    chk("R8 ext set", sum, 6'b001000);
    chk("R8 latched value", stat_a_q, stat_a);
    begin
      logic [1:0] held;
      held = stat_a;
      @(negedge clk); stat_a = stat_a ^ 2'b01; @(negedge clk);
      chk("R8 frozen", stat_a_q, held);
    end
    wr(0, 0, 8'h01);
    chk("R8 reset ext", sum, 0);
    chk("R8 rearmed view", stat_a_q, stat_a);
    @(negedge clk); stat_a = stat_a ^ 2'b01; @(negedge clk);
    chk("R8 new change", sum, 6'b001000);
    wr(0, 0, 8'h01);

    // R5 R6 nesting
    rxc(2'b10);
    chk("R5 B rx irq", irq, 1);
    ack();
    chk("R5 own ius blocks", irq, 0);
    chk("R11 ieo in service", ieo, 0);
    @(negedge clk); stat_a = stat_a ^ 2'b01; @(negedge clk);
    chk("R5 higher nests", irq, 1);
    chk("R5 vec A ext", vec, ev(2, 0));
    @(negedge clk); tx_empty = 2'b10; @(negedge clk);
    chk("R2 A ext over B tx", vec, ev(2, 0));
    ack();
    chk("R5 both in service", irq, 0);
    wr(0, 0, 8'h01);
    wr(0, 0, 8'h04);
    chk("R6 B rx still in service", irq, 0);
    rdx(2'b10);
    chk("R5 B tx blocked", irq, 0);
    wr(0, 0, 8'h04);
    chk("R6 B tx released", irq, 1);
    chk("R6 vec B tx", vec, ev(4, 0));
    chk("R6 ieo back", ieo, 1);
    @(negedge clk); tx_empty = 0; @(negedge clk);

    // R11 daisy chain
    rxc(2'b01);
    @(negedge clk); iei = 0; #1;
    chk("R11 iei low irq", irq, 0);
    chk("R11 iei low ieo", ieo, 0);
    @(negedge clk); iei = 1; #1;
    chk("R11 iei high irq", irq, 1);
    wr(2, 0, 8'h05);
    chk("R11 dlc ieo", ieo, 0);
    wr(2, 0, 8'h01);
    chk("R11 dlc clear ieo", ieo, 1);
    rdx(2'b01);
    chk("R2 all clear irq", irq, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule